// File: doc/BRIEF.md
# Issue Queue Slot Occupancy and Squash Manager

This block keeps the occupancy bookkeeping for an out-of-order issue queue with a parameterised number of slots. Each slot stores the sequence number of the instruction placed in it, a busy bit, an issued bit and a squashed bit. A slot counts as live while it is busy and neither issued nor squashed. The block reports how many slots are free and whether the queue is full. It also hands out slots to new instructions, lowest index first.

An issue request names a slot that selection logic has chosen. The block retires that slot and gives it back to the free pool. A squash request carries a boundary sequence number. In a single cycle every slot is compared against the boundary in parallel. Each live slot holding a strictly younger instruction is released and reported on a one-cycle release vector, so that the dependency tracker can drop those slots. A released slot is also marked issued and ready to retire, so selection can never pick it again.

Within one cycle the work is done in a fixed order: squash first, then issue, then insert. An insert in the same cycle as a squash may therefore land in a slot that the squash has just freed.

Top module: `iq_occupancy`

## Requirements
- R1: After reset, free_cnt equals ENTRIES, and release_vec, ins_overflow and bad_boundary are all zero. At every cycle, full is 1 exactly when free_cnt is 0.
- R2: An accepted insert goes to the lowest-index slot that is not live after that cycle's squash. That index is shown on alloc_slot in the same cycle. free_cnt drops by one at the next clock edge.
- R3: An insert that finds no free slot after that cycle's squash is dropped. ins_overflow is then 1 for exactly one cycle after the edge, and free_cnt is not reduced by it.
- R4: An issue request for a live slot retires that slot and raises free_cnt by one at the next edge. An issue request for a slot that is not live has no effect.
- R5: A squash releases every live slot whose sequence number is strictly greater than the boundary. Sequence numbers are compared as unsigned values. Bit i of release_vec is 1 for exactly the one cycle after the edge, and free_cnt rises by the number of slots released.
- R6: A slot that has already issued, or that was squashed earlier, is never released again. A squashed slot counts as issued, so a later issue request naming it has no effect.
- R7: A squash request while no slot is live releases nothing and raises no error flag.
- R8: A squash request with a boundary of zero while at least one slot is live releases nothing. bad_boundary is then 1 for exactly one cycle after the edge.
- R9: A squash, an issue and an insert in the same cycle are applied in the order squash, issue, insert. The insert may take a slot freed by the squash, and free_cnt reflects all three at the next edge.
- R10: free_cnt always equals ENTRIES minus the number of live slots.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert request |
| ins_seq | input | SEQ_W | Sequence number of the inserted instruction |
| alloc_slot | output | $clog2(ENTRIES) | Slot an insert in this cycle would take |
| iss_valid | input | 1 | Issue request |
| iss_slot | input | $clog2(ENTRIES) | Slot being issued |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Squash boundary; strictly younger entries are removed |
| free_cnt | output | $clog2(ENTRIES+1) | Number of free slots |
| full | output | 1 | No free slot |
| release_vec | output | ENTRIES | One-cycle pulse per slot released by a squash |
| ins_overflow | output | 1 | One-cycle pulse: an insert found the queue full |
| bad_boundary | output | 1 | One-cycle pulse: a squash carried a zero boundary |

## Verification
Errors in the per-slot flags show up at the ports within one or two cycles. A slot wrongly left live keeps free_cnt too low. It also shifts the index given on alloc_slot to the next insert, and it reappears as an unexpected bit in release_vec on the next squash that covers its sequence number. A slot wrongly cleared shows the opposite pattern: free_cnt is too high, and an issue request naming that slot fails to raise the count. The bench therefore reads free_cnt, full, release_vec and both error pulses one edge after each request, and alloc_slot in the cycle of the request. Stimulus is chosen so that every kind of flag error moves one of those values.

// File: rtl/iq_pkg.sv
package iq_pkg;

    // Outcome of evaluating a squash request against the queue state.
    typedef enum logic [1:0] {
        SQ_NONE      = 2'd0,
        SQ_APPLY     = 2'd1,
        SQ_BAD_BOUND = 2'd2
    } sq_action_e;

endpackage

// File: rtl/iq_squash_scan.sv
module iq_squash_scan
    import iq_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int SEQ_W   = 8
) (
    input  logic                            req,
    input  logic [SEQ_W-1:0]                boundary,
    input  logic [ENTRIES-1:0][SEQ_W-1:0]   slot_seq,
    input  logic [ENTRIES-1:0]              live,
    output sq_action_e                      action,
    output logic [ENTRIES-1:0]              kill
);

    logic                any_live;
    logic [ENTRIES-1:0]  younger;

    assign any_live = |live;

    // One comparator per slot: the whole queue is judged in one cycle.
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign younger[i] = live[i] && (slot_seq[i] > boundary);
    end

    always_comb begin
        action = SQ_NONE;
        if (req && any_live) begin
            action = (boundary == '0) ? SQ_BAD_BOUND : SQ_APPLY;
        end
        kill = (action == SQ_APPLY) ? younger : '0;
    end

endmodule

// File: rtl/iq_free_pick.sv
module iq_free_pick #(
    parameter int ENTRIES = 8,
    localparam int SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0] free_mask,
    output logic               found,
    output logic [SLOT_W-1:0]  idx
);

    // Lowest index wins: scan from the top so the last hit is the lowest.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (free_mask[i]) begin
                found = 1'b1;
                idx   = SLOT_W'(i);
            end
        end
    end

endmodule

// File: rtl/iq_popcount.sv
module iq_popcount #(
    parameter int ENTRIES = 8,
    localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
    input  logic [ENTRIES-1:0] mask,
    output logic [CNT_W-1:0]   count
);

    always_comb begin
        count = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            count = count + CNT_W'(mask[i]);
        end
    end

endmodule

// File: rtl/iq_occupancy.sv
module iq_occupancy
    import iq_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int SEQ_W   = 8,
    localparam int SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ins_valid,
    input  logic [SEQ_W-1:0]   ins_seq,
    output logic [SLOT_W-1:0]  alloc_slot,
    input  logic               iss_valid,
    input  logic [SLOT_W-1:0]  iss_slot,
    input  logic               sq_valid,
    input  logic [SEQ_W-1:0]   sq_seq,
    output logic [CNT_W-1:0]   free_cnt,
    output logic               full,
    output logic [ENTRIES-1:0] release_vec,
    output logic               ins_overflow,
    output logic               bad_boundary
);

    typedef struct packed {
        logic [ENTRIES-1:0][SEQ_W-1:0] seq;
        logic [ENTRIES-1:0]            busy;
        logic [ENTRIES-1:0]            issued;
        logic [ENTRIES-1:0]            squashed;
        logic [CNT_W-1:0]              free_cnt;
        logic                          full;
        logic [ENTRIES-1:0]            rel;
        logic                          ins_err;
        logic                          sq_err;
    } state_t;

    state_t st_q, st_d;

    logic [ENTRIES-1:0] live_q;
    logic [ENTRIES-1:0] kill;
    logic [ENTRIES-1:0] live_post_sq;
    logic [CNT_W-1:0]   kill_cnt;
    logic               pick_found;
    logic [SLOT_W-1:0]  pick_idx;
    sq_action_e         sq_act;

    assign live_q       = st_q.busy & ~st_q.issued & ~st_q.squashed;
    assign live_post_sq = live_q & ~kill;

    iq_squash_scan #(
        .ENTRIES (ENTRIES),
        .SEQ_W   (SEQ_W)
    ) u_scan (
        .req      (sq_valid),
        .boundary (sq_seq),
        .slot_seq (st_q.seq),
        .live     (live_q),
        .action   (sq_act),
        .kill     (kill)
    );

    iq_popcount #(
        .ENTRIES (ENTRIES)
    ) u_kill_cnt (
        .mask  (kill),
        .count (kill_cnt)
    );

    iq_free_pick #(
        .ENTRIES (ENTRIES)
    ) u_pick (
        .free_mask (~live_post_sq),
        .found     (pick_found),
        .idx       (pick_idx)
    );

    always_comb begin
        logic iss_ok;
        logic ins_ok;

        st_d         = st_q;
        st_d.rel     = '0;
        st_d.ins_err = 1'b0;
        st_d.sq_err  = (sq_act == SQ_BAD_BOUND);

        // Step 1: squash. A released slot becomes issued as well, so it
        // is retired and selection can never name it again.
        st_d.rel      = kill;
        st_d.squashed = st_q.squashed | kill;
        st_d.issued   = st_q.issued | kill;

        // Step 2: issue, only for a slot still live after the squash.
        iss_ok = 1'b0;
        if (iss_valid && (int'(iss_slot) < ENTRIES)) begin
            if (live_post_sq[iss_slot]) begin
                iss_ok = 1'b1;
                st_d.issued[iss_slot] = 1'b1;
            end
        end

        // Step 3: insert into the lowest slot left free by the squash.
        // A slot issued this cycle is still live in live_post_sq, so it
        // is never chosen.
        ins_ok = 1'b0;
        if (ins_valid) begin
            if (pick_found) begin
                ins_ok                   = 1'b1;
                st_d.seq[pick_idx]       = ins_seq;
                st_d.busy[pick_idx]      = 1'b1;
                st_d.issued[pick_idx]    = 1'b0;
                st_d.squashed[pick_idx]  = 1'b0;
            end else begin
                st_d.ins_err = 1'b1;
            end
        end

        st_d.free_cnt = st_q.free_cnt + kill_cnt + CNT_W'(iss_ok)
                        - CNT_W'(ins_ok);
        st_d.full     = (st_d.free_cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.free_cnt <= CNT_W'(ENTRIES);
            st_q.full     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign alloc_slot   = pick_idx;
    assign free_cnt     = st_q.free_cnt;
    assign full         = st_q.full;
    assign release_vec  = st_q.rel;
    assign ins_overflow = st_q.ins_err;
    assign bad_boundary = st_q.sq_err;

    // The full flag is kept in its own register and must agree with the count.
    p_full_tracks_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
        full == (free_cnt == '0));

    // The running counter must match the number of live slots (R10).
    p_count_matches_live_r10: assert property (@(posedge clk) disable iff (!rst_n)
        free_cnt == CNT_W'(ENTRIES - $countones(live_q)));

    // A rejected insert leaves the count as it was (R3).
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && full && !sq_valid && !iss_valid) |=> (ins_overflow && free_cnt == '0));

    // Only slots that were live are ever released (R5, R6).
    p_release_only_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((release_vec & ~$past(live_q)) == '0));

    // A squash on an empty queue is silent (R7).
    p_empty_squash_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_valid && live_q == '0) |=> (release_vec == '0 && !bad_boundary));

    // A zero boundary on a non-empty queue is flagged and releases nothing (R8).
    p_zero_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_valid && sq_seq == '0 && live_q != '0) |=> (bad_boundary && release_vec == '0));

endmodule

// File: tb/iq_occupancy_test.sv
`timescale 1ns/1ps
module iq_occupancy_test;

    localparam int N      = 4;
    localparam int SW     = 8;
    localparam int SLOT_W = 2;
    localparam int CNT_W  = 3;
    localparam int ROWS   = 19;

    typedef struct packed {
        logic          ins_v;
        logic [SW-1:0] ins_seq;
        logic          iss_v;
        logic [1:0]    iss_slot;
        logic          sq_v;
        logic [SW-1:0] sq_seq;
        logic [3:0]    e_slot;   // 4'hF: not checked
        logic [2:0]    e_free;
        logic [3:0]    e_rel;
        logic          e_ierr;
        logic          e_serr;
    } vec_t;

    localparam vec_t TBL [ROWS] = '{
        '{1'b1, 8'd10, 1'b0, 2'd0, 1'b0, 8'd0,  4'd0, 3'd3, 4'b0000, 1'b0, 1'b0}, // R2
        '{1'b1, 8'd11, 1'b0, 2'd0, 1'b0, 8'd0,  4'd1, 3'd2, 4'b0000, 1'b0, 1'b0}, // R2
        '{1'b1, 8'd12, 1'b0, 2'd0, 1'b0, 8'd0,  4'd2, 3'd1, 4'b0000, 1'b0, 1'b0}, // R2
        '{1'b1, 8'd13, 1'b0, 2'd0, 1'b0, 8'd0,  4'd3, 3'd0, 4'b0000, 1'b0, 1'b0}, // R1 full
        '{1'b1, 8'd14, 1'b0, 2'd0, 1'b0, 8'd0,  4'hF, 3'd0, 4'b0000, 1'b1, 1'b0}, // R3
        '{1'b0, 8'd0,  1'b1, 2'd1, 1'b0, 8'd0,  4'hF, 3'd1, 4'b0000, 1'b0, 1'b0}, // R4
        '{1'b0, 8'd0,  1'b0, 2'd0, 1'b1, 8'd11, 4'hF, 3'd3, 4'b1100, 1'b0, 1'b0}, // R5 R6
        '{1'b0, 8'd0,  1'b1, 2'd2, 1'b0, 8'd0,  4'hF, 3'd3, 4'b0000, 1'b0, 1'b0}, // R6
        '{1'b0, 8'd0,  1'b0, 2'd0, 1'b1, 8'd5,  4'hF, 3'd4, 4'b0001, 1'b0, 1'b0}, // R5
        '{1'b0, 8'd0,  1'b0, 2'd0, 1'b1, 8'd0,  4'hF, 3'd4, 4'b0000, 1'b0, 1'b0}, // R7
        '{1'b1, 8'd20, 1'b0, 2'd0, 1'b0, 8'd0,  4'd0, 3'd3, 4'b0000, 1'b0, 1'b0}, // R2
        '{1'b0, 8'd0,  1'b0, 2'd0, 1'b1, 8'd0,  4'hF, 3'd3, 4'b0000, 1'b0, 1'b1}, // R8
        '{1'b1, 8'd21, 1'b0, 2'd0, 1'b0, 8'd0,  4'd1, 3'd2, 4'b0000, 1'b0, 1'b0}, // R2
        '{1'b1, 8'd22, 1'b0, 2'd0, 1'b0, 8'd0,  4'd2, 3'd1, 4'b0000, 1'b0, 1'b0}, // R2
        '{1'b1, 8'd23, 1'b0, 2'd0, 1'b0, 8'd0,  4'd3, 3'd0, 4'b0000, 1'b0, 1'b0}, // R2
        '{1'b1, 8'd30, 1'b0, 2'd0, 1'b1, 8'd21, 4'd2, 3'd1, 4'b1100, 1'b0, 1'b0}, // R9 R5
        '{1'b0, 8'd0,  1'b0, 2'd0, 1'b1, 8'd29, 4'hF, 3'd2, 4'b0100, 1'b0, 1'b0}, // R5
        '{1'b1, 8'd40, 1'b1, 2'd0, 1'b0, 8'd0,  4'd2, 3'd2, 4'b0000, 1'b0, 1'b0}, // R9 R4
        '{1'b0, 8'd0,  1'b0, 2'd0, 1'b1, 8'd10, 4'hF, 3'd4, 4'b0110, 1'b0, 1'b0}  // R6 R10
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic              ins_valid;
    logic [SW-1:0]     ins_seq;
    logic [SLOT_W-1:0] alloc_slot;
    logic              iss_valid;
    logic [SLOT_W-1:0] iss_slot;
    logic              sq_valid;
    logic [SW-1:0]     sq_seq;
    logic [CNT_W-1:0]  free_cnt;
    logic              full;
    logic [N-1:0]      release_vec;
    logic              ins_overflow;
    logic              bad_boundary;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    iq_occupancy #(.ENTRIES(N), .SEQ_W(SW)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ins_valid    (ins_valid),
        .ins_seq      (ins_seq),
        .alloc_slot   (alloc_slot),
        .iss_valid    (iss_valid),
        .iss_slot     (iss_slot),
        .sq_valid     (sq_valid),
        .sq_seq       (sq_seq),
        .free_cnt     (free_cnt),
        .full         (full),
        .release_vec  (release_vec),
        .ins_overflow (ins_overflow),
        .bad_boundary (bad_boundary)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        ins_valid = 1'b0; ins_seq = '0;
        iss_valid = 1'b0; iss_slot = '0;
        sq_valid  = 1'b0; sq_seq  = '0;
    endtask

    task automatic check_reset_state(input string tag);
        chk(tag, "free_cnt", int'(free_cnt), N);
        chk(tag, "full", int'(full), 0);
        chk(tag, "release_vec", int'(release_vec), 0);
        chk(tag, "ins_overflow", int'(ins_overflow), 0);
        chk(tag, "bad_boundary", int'(bad_boundary), 0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_reset_state("R1");

        // Table walk: drive on the falling edge, read alloc_slot in the same
        // cycle, read registered outputs on the next falling edge.
        for (int r = 0; r < ROWS; r++) begin
            ins_valid = TBL[r].ins_v;  ins_seq  = TBL[r].ins_seq;
            iss_valid = TBL[r].iss_v;  iss_slot = TBL[r].iss_slot;
            sq_valid  = TBL[r].sq_v;   sq_seq   = TBL[r].sq_seq;
            #1;
            if (TBL[r].e_slot != 4'hF)
                chk("R2", $sformatf("row %0d alloc_slot", r), int'(alloc_slot), int'(TBL[r].e_slot));
            @(negedge clk);
            chk("R10", $sformatf("row %0d free_cnt", r), int'(free_cnt), int'(TBL[r].e_free));
            chk("R1", $sformatf("row %0d full", r), int'(full), (TBL[r].e_free == 0) ? 1 : 0);
            chk("R5", $sformatf("row %0d release_vec", r), int'(release_vec), int'(TBL[r].e_rel));
            chk("R3", $sformatf("row %0d ins_overflow", r), int'(ins_overflow), int'(TBL[r].e_ierr));
            chk("R8", $sformatf("row %0d bad_boundary", r), int'(bad_boundary), int'(TBL[r].e_serr));
        end

        // Error and release pulses last a single cycle (R3, R5, R8).
        idle_inputs();
        ins_valid = 1'b1; ins_seq = 8'd50;
        @(negedge clk);
        ins_valid = 1'b0;
        sq_valid = 1'b1; sq_seq = 8'd0;
        @(negedge clk);
        sq_valid = 1'b0;
        chk("R8", "zero boundary pulse", int'(bad_boundary), 1);
        @(negedge clk);
        chk("R8", "pulse cleared", int'(bad_boundary), 0);
        chk("R5", "no release on idle cycle", int'(release_vec), 0);
        chk("R4", "count after one insert", int'(free_cnt), N - 1);

        // Issue of a slot that was never filled changes nothing (R4).
        iss_valid = 1'b1; iss_slot = 2'd3;
        @(negedge clk);
        iss_valid = 1'b0;
        chk("R4", "issue of empty slot ignored", int'(free_cnt), N - 1);

        // Reset in mid-run restores the idle state (R1).
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check_reset_state("R1");
        #1;
        chk("R2", "first slot after reset", int'(alloc_slot), 0);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule